// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a standard-mode two-wire serial slave that keeps six 8-bit configuration bytes for a clock synthesizer. The bytes hold output enables and frequency-select settings. In the enable bytes, a 1 lets the corresponding output run and a 0 holds it low. The slave has no register pointer. A write always starts at byte 0 and moves upward. On a read, the slave first sends a byte count and then sends every byte.

While reset is high, the block samples five strap inputs into a latch. It then holds that value for as long as reset stays low. The latched straps appear in the last byte as the inverse of the sampled levels. They also provide the frequency select whenever the programmable-select bit in byte 0 is clear. SCL and SDA are sampled on the system clock through two-flop synchronizers. The slave pulls SDA low through an open-drain control output.

Top module: `smb_cfg_slave`

## Requirements
- R1: While `rst` is high, and after it falls until the first write, the bytes read (byte 0 first) 0x00, 0x0F, 0xFF, 0x3F, 0x00. Byte 5 holds `{~strap, 3'b111}`. `sda_drive_low` is 0.
- R2: The slave acknowledges the 8-bit address 0xD2 as a write and 0xD3 as a read. For any other address it gives no acknowledge and takes no action on any bytes that follow until the next START.
- R3: On a write, the slave acknowledges the two bytes after the address and discards them. The configuration does not change.
- R4: The third and later bytes of a write go to byte 0, then byte 1, and so on. A STOP after any complete byte leaves the bytes not yet reached at their old values.
- R5: The slave acknowledges data bytes past byte 5 and they change nothing.
- R6: After a read address, the slave sends the count 6, MSB first. It then sends bytes 0 to 5 for as long as the master acknowledges. A master NACK ends the transfer.
- R7: The straps are sampled only while `rst` is high. Bits [7:3] of byte 5 read `~strap[4:0]`, and writes do not change these bits. Only bits [2:0] of byte 5 can be written.
- R8: When bit 3 of byte 0 is 1, `fsel_o` equals byte 0 bits [7:4]. When that bit is 0, `fsel_o` equals the latched `strap[3:0]` levels.
- R9: A START or STOP in the middle of a byte discards the partial byte. A repeated START restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap sampling window |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain control) |
| strap_i | input | 5 | Strap pin levels, sampled during reset |
| cfg_o | output | 48 | Configuration bytes, byte k at [8k+7:8k] |
| fsel_o | output | 4 | Effective frequency select |

## Verification
A bus condition and the end of a byte can fall on the same cycle. In that case the START or STOP decision takes priority, and the bit-level byte assembly and acknowledge sequencing give way to it. The bench provokes this in two ways. It sends four bits of a data byte and then a STOP. It also issues a repeated START straight after a command-byte acknowledge. Pass means byte 0 keeps its earlier value after the aborted byte. It also means the write that follows the restart lands in byte 0 and not one position later.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    // Power-on value of each configuration byte (last byte: writable low bits only)
    function automatic logic [BYTE_W-1:0] byte_default(input int k);
        case (k)
            1:       return 8'h0F;
            2:       return 8'hFF;
            3:       return 8'h3F;
            5:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/smb_engine.sv
module smb_engine
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_BYTES = 6,
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    localparam int        IW        = $clog2(NUM_BYTES),
    localparam int        PW        = $clog2(NUM_BYTES + 3) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [7:0]    rd_data,
    output logic [IW-1:0] rd_idx,
    output wr_req_t       wr,
    output logic          sda_low,
    output phase_e        phase
);

    logic [2:0]    bit_cnt;
    logic [7:0]    shreg;
    logic [6:0]    txsh;
    logic [PW-1:0] pos;
    logic [PW-1:0] pos_inc;
    logic          addr_phase;
    logic          is_read;
    logic          byte_done;
    logic          m_ack;
    logic [7:0]    tx_byte;

    assign pos_inc = (&pos) ? pos : pos + 1'b1;

    // Byte to send: count first, then stored bytes, then idle-high filler
    always_comb begin
        rd_idx  = '0;
        tx_byte = 8'hFF;
        if (pos == '0) begin
            tx_byte = 8'(NUM_BYTES);
        end else if (int'(pos) - 1 < NUM_BYTES) begin
            rd_idx  = IW'(int'(pos) - 1);
            tx_byte = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txsh       <= '0;
            pos        <= '0;
            addr_phase <= 1'b0;
            is_read    <= 1'b0;
            byte_done  <= 1'b0;
            m_ack      <= 1'b0;
            sda_low    <= 1'b0;
            wr         <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (ev.start) begin
                phase      <= PH_RX;
                bit_cnt    <= '0;
                byte_done  <= 1'b0;
                addr_phase <= 1'b1;
                is_read    <= 1'b0;
                sda_low    <= 1'b0;
            end else if (ev.stop) begin
                phase     <= PH_IDLE;
                byte_done <= 1'b0;
                sda_low   <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (ev.rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) byte_done <= 1'b1;
                        end else if (ev.fall && byte_done) begin
                            byte_done <= 1'b0;
                            if (addr_phase) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read    <= shreg[0];
                                    addr_phase <= 1'b0;
                                    pos        <= '0;
                                    sda_low    <= 1'b1;
                                    phase      <= PH_RX_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                sda_low <= 1'b1;
                                phase   <= PH_RX_ACK;
                                pos     <= pos_inc;
                                if (int'(pos) >= 2 && int'(pos) - 2 < NUM_BYTES) begin
                                    wr.valid <= 1'b1;
                                    wr.idx   <= 8'(int'(pos) - 2);
                                    wr.data  <= shreg;
                                end
                            end
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            if (is_read) begin
                                phase   <= PH_TX;
                                txsh    <= tx_byte[6:0];
                                sda_low <= ~tx_byte[7];
                                bit_cnt <= '0;
                                pos     <= pos_inc;
                            end else begin
                                sda_low <= 1'b0;
                                bit_cnt <= '0;
                                phase   <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_low <= 1'b0;
                                phase   <= PH_TX_ACK;
                            end else begin
                                sda_low <= ~txsh[6];
                                txsh    <= {txsh[5:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) m_ack <= ~ev.sda;
                        if (ev.fall) begin
                            if (m_ack) begin
                                phase   <= PH_TX;
                                txsh    <= tx_byte[6:0];
                                sda_low <= ~tx_byte[7];
                                bit_cnt <= '0;
                                pos     <= pos_inc;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_cfg_store.sv
module smb_cfg_store
    import smb_cfg_pkg::*;
#(
    parameter int  NUM_BYTES = 6,
    parameter int  STRAP_W   = 5,
    localparam int IW        = $clog2(NUM_BYTES),
    localparam int LOW_W     = BYTE_W - STRAP_W,
    localparam int FS_W      = STRAP_W - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [STRAP_W-1:0]          strap_i,
    input  wr_req_t                     wr,
    input  logic [IW-1:0]               rd_idx,
    output logic [7:0]                  rd_data,
    output logic [BYTE_W*NUM_BYTES-1:0] cfg_flat,
    output logic [FS_W-1:0]             strap_fs
);

    logic [STRAP_W-1:0] strap_q;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    assign strap_fs = strap_q[FS_W-1:0];

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam logic [7:0] DEF = byte_default(k);
        if (k == NUM_BYTES - 1) begin : g_rb
            logic [LOW_W-1:0] low_q;
            always_ff @(posedge clk) begin
                if (rst)                              low_q <= DEF[LOW_W-1:0];
                else if (wr.valid && wr.idx == 8'(k)) low_q <= wr.data[LOW_W-1:0];
            end
            assign cfg_flat[BYTE_W*k +: BYTE_W] = {~strap_q, low_q};
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)                              q <= DEF;
                else if (wr.valid && wr.idx == 8'(k)) q <= wr.data;
            end
            assign cfg_flat[BYTE_W*k +: BYTE_W] = q;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (int'(rd_idx) < NUM_BYTES) rd_data = cfg_flat[BYTE_W*rd_idx +: BYTE_W];
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_BYTES   = 6,
    parameter int         STRAP_W     = 5,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_drive_low,
    input  logic [STRAP_W-1:0]     strap_i,
    output logic [8*NUM_BYTES-1:0] cfg_o,
    output logic [STRAP_W-2:0]     fsel_o
);

    localparam int IW       = $clog2(NUM_BYTES);
    localparam int FS_W     = STRAP_W - 1;
    localparam int MODE_BIT = 3;

    bus_ev_t       ev;
    wr_req_t       wr;
    logic [IW-1:0] rd_idx;
    logic [7:0]    rd_data;
    logic [FS_W-1:0] strap_fs;
    phase_e        eng_phase;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_engine #(.NUM_BYTES(NUM_BYTES), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr      (wr),
        .sda_low (sda_drive_low),
        .phase   (eng_phase)
    );

    smb_cfg_store #(.NUM_BYTES(NUM_BYTES), .STRAP_W(STRAP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap_i),
        .wr       (wr),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cfg_flat (cfg_o),
        .strap_fs (strap_fs)
    );

    assign fsel_o = cfg_o[MODE_BIT] ? cfg_o[7 -: FS_W] : strap_fs;

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int NUM_BYTES = 6,
    parameter int STRAP_W   = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sda_drive_low,
    input logic [8*NUM_BYTES-1:0] cfg_o,
    input logic [STRAP_W-2:0]     fsel_o,
    input logic                   fall_evt,
    input phase_e                 eng_phase
);

    localparam int TOP = 8 * NUM_BYTES;

    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_o[23:0] == 24'hFF0F00 && !sda_drive_low));

    // R7
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_o[TOP-1 -: STRAP_W]));

    // R8
    fsel_strap_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_o[3] |-> (fsel_o == ~cfg_o[TOP-2 -: STRAP_W-1]));

    // R4
    cfg_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o[TOP-STRAP_W-1:0]) |-> $past(fall_evt, 2));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_phase == PH_IDLE) |-> !sda_drive_low);

    // R6
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> $past(fall_evt));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_BYTES(NUM_BYTES), .STRAP_W(STRAP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sda_drive_low (sda_drive_low),
    .cfg_o         (cfg_o),
    .fsel_o        (fsel_o),
    .fall_evt      (ev.fall),
    .eng_phase     (eng_phase)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [4:0]  strap = 5'b10110;
    logic        sda_low;
    logic [47:0] cfg;
    logic [3:0]  fsel;
    wire         sda_line = sda_m & ~sda_low;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  model [6];
    logic [4:0]  strap_lat;
    bit          mon_en = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    smb_cfg_slave u_smb_cfg_slave (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_drive_low (sda_low),
        .strap_i       (strap),
        .cfg_o         (cfg),
        .fsel_o        (fsel)
    );

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int k = 0; k < 6; k++) f[8*k +: 8] = model[k];
        return f;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model compared every clock outside byte-commit windows
    always @(negedge clk) begin
        if (mon_en && !done) begin
            checks++;
            if (cfg !== model_flat()) begin
                errors++;
                $display("FAIL R4 model: actual=%h expected=%h", cfg, model_flat());
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(2*Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        b = sda_line; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) send_bit(d[7-i]);
    endtask

    task automatic wbyte(input logic [7:0] d, input int upd, output logic ack);
        logic b;
        mon_en = 1'b0;
        send_bits(d, 8);
        read_bit(b);
        ack = ~b;
        if (upd >= 0 && upd < 5) model[upd] = d;
        else if (upd == 5) model[5] = {~strap_lat, d[2:0]};
        mon_en = 1'b1;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            read_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        strap_lat = 5'b10110;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1 defaults, byte 5 = {~10110, 111} = 0x4F
        model[0] = 8'h00; model[1] = 8'h0F; model[2] = 8'hFF;
        model[3] = 8'h3F; model[4] = 8'h00; model[5] = 8'h4F;
        check("R1 defaults", cfg, 48'h4F003FFF0F00);
        check("R1 sda idle", sda_low, 1'b0);
        check("R8 fsel from straps", fsel, 4'h6);
        mon_en = 1'b1;

        // R7: strap change after reset has no effect
        strap = 5'b01001;
        wait_cyc(20);
        check("R7 strap held", cfg[47:40], 8'h4F);
        check("R7 fsel held", fsel, 4'h6);

        // Write: address, dummy command/count, two data bytes
        bus_start();
        wbyte(8'hD2, -1, ack); check("R2 write addr ack", ack, 1'b1);
        wbyte(8'hAA, -1, ack); check("R3 cmd ack", ack, 1'b1);
        wbyte(8'h55, -1, ack); check("R3 count ack", ack, 1'b1);
        check("R3 dummies discarded", cfg, 48'h4F003FFF0F00);
        wbyte(8'h5A, 0, ack);  check("R4 data0 ack", ack, 1'b1);
        wbyte(8'h11, 1, ack);  check("R4 data1 ack", ack, 1'b1);
        bus_stop();
        check("R4 partial write", cfg, 48'h4F003FFF115A);
        check("R8 fsel programmed", fsel, 4'h5);

        // Full write plus two extra bytes
        bus_start();
        wbyte(8'hD2, -1, ack);
        wbyte(8'h00, -1, ack);
        wbyte(8'h08, -1, ack);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = (k == 5) ? 8'hF8 : (k == 6) ? 8'hE7 : (k == 7) ? 8'hD6 : 8'(k + 1);
            wbyte(v, k, ack);
            if (k >= 6) check("R5 extra byte ack", ack, 1'b1);
        end
        bus_stop();
        check("R7 byte5 readback bits", cfg[47:40], 8'h48);
        check("R5 extra bytes ignored", cfg, 48'h480504030201);
        check("R8 fsel strap again", fsel, 4'h6);

        // Wrong address
        bus_start();
        wbyte(8'hA0, -1, ack); check("R2 foreign addr nack", ack, 1'b0);
        wbyte(8'h77, -1, ack); check("R2 ignored after mismatch", ack, 1'b0);
        bus_stop();
        check("R2 cfg untouched", cfg, model_flat());

        // Block read
        bus_start();
        wbyte(8'hD3, -1, ack); check("R6 read addr ack", ack, 1'b1);
        rbyte(1'b0, d);        check("R6 byte count", d, 8'd6);
        for (int k = 0; k < 6; k++) begin
            rbyte(k == 5, d);
            check("R6 read data", d, model[k]);
        end
        bus_stop();

        // R9: STOP in the middle of a byte
        bus_start();
        wbyte(8'hD2, -1, ack);
        wbyte(8'h00, -1, ack);
        wbyte(8'h00, -1, ack);
        send_bits(8'hC3, 4);
        bus_stop();
        check("R9 aborted byte", cfg[7:0], 8'h01);

        // R9: repeated START restarts the sequence
        bus_start();
        wbyte(8'hD2, -1, ack);
        wbyte(8'h00, -1, ack);
        bus_start();
        wbyte(8'hD2, -1, ack); check("R9 restart addr ack", ack, 1'b1);
        wbyte(8'h00, -1, ack);
        wbyte(8'h00, -1, ack);
        wbyte(8'h9C, 0, ack);
        bus_stop();
        check("R9 write after restart", cfg[15:0], 16'h029C);
        check("R8 fsel after restart", fsel, 4'h9);

        wait_cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule